// File: doc/BRIEF.md
# Blanking-Interval Audio Inserter

This transmit-side block runs in the pixel clock domain and builds the 27-bit parallel word that feeds a video serializer. The RGB data and the three timing bits (vertical sync, horizontal sync, data enable) pass straight through. A stereo PCM stream is sent as an I2S-style serial stream on spare control bits, and only while data enable is low, which marks the blanking period.

Stereo samples arrive on a valid/ready handshake. Each frame holds a left word and a right word and is shifted out one bit per bit period. The block has two transfer modes. In pixel-clock mode the pixel clock itself is the far end's bit clock, and an active-low select gates the transfer. In divided-clock mode the block toggles a bit clock on a control bit and stops it low to pause. When active video interrupts a frame, the transfer freezes where it stands and continues in the next blanking gap.

Top module: `blank_audio_inserter`

## Requirements
- R1: `word_o[17:0]` equals `rgb_i`, and `word_o[18]`, `word_o[19]` and `word_o[20]` (control bits C0, C1, C2) equal `vsync_i`, `hsync_i` and `de_i` in the same cycle, in every mode.
- R2: `word_o[25]` and `word_o[26]` (C7, C8) are always 0.
- R3: While `de_i` is 1, the bit clock `word_o[23]` (C5) is 0 and the select `word_o[24]` (C6) is 1, so no bit is transferred.
- R4: In pixel-clock mode (`mode_i` = 0), during blanking with a frame pending, C6 is 0, C5 is 0 and a new bit appears on `word_o[21]` (C3) every pixel cycle.
- R5: In divided-clock mode (`mode_i` = 1), C6 stays 1. During blanking with a frame pending, C5 is low for DIV_HALF cycles and then high for DIV_HALF cycles. Each bit is held on C3 for one full period, so C3 does not change in a cycle where C5 rises.
- R6: A frame is 2×SAMPLE_W bits, sent MSB first: the left word first, then the right word.
- R7: Word select on `word_o[22]` (C4) is 0 for left bits and 1 for right bits, except that it changes one bit early. It is 1 during the left LSB and 0 during the right LSB.
- R8: When active video starts in the middle of a frame, the bit position, bit-clock phase and C3/C4 hold their values. The transfer resumes in the next blanking gap with no bit lost or repeated.
- R9: `aud_ready` is 1 only while no frame is pending. A frame is taken when `aud_valid` and `aud_ready` are both 1 at a clock edge. `aud_ready` is then 0 until the cycle after the right LSB has been transferred.
- R10: While reset is asserted, and for two clocks after it is released, `aud_ready` is 0. After that the block is idle with `aud_ready` at 1.
- R11: With no frame pending, C3 and C4 are 0, C5 is 0 and C6 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0: pixel clock is the bit clock; 1: divided bit clock on C5 |
| rgb_i | input | 18 | Pixel colour data, 6 bits per primary |
| vsync_i | input | 1 | Vertical sync |
| hsync_i | input | 1 | Horizontal sync |
| de_i | input | 1 | Data enable; low means blanking |
| aud_valid | input | 1 | A stereo sample is offered |
| aud_left | input | 16 | Left-channel sample |
| aud_right | input | 16 | Right-channel sample |
| aud_ready | output | 1 | The block can take a stereo sample |
| word_o | output | 27 | Serializer word: `[17:0]` RGB, `[26:18]` control bits C0..C8 |

## Verification
The bench targets blanking gaps that are shorter than a frame, including gaps of an odd length that cut a divided-clock period in half. A design that advanced its position during video, or reset its phase at each gap, would drop or repeat bits, and the far-end receiver model would then rebuild wrong samples. Word-select timing is checked at every captured bit: a design that changed it on the MSB instead of one bit earlier would fail there. The handshake is checked back to back, so a design that took a new sample before the right LSB had left, or that left a cycle of the bit clock high during video, would be caught against the cycle-by-cycle model.

// File: rtl/bai_pkg.sv
package bai_pkg;
  localparam int CTL_W   = 9;
  localparam int C_VSYNC = 0;
  localparam int C_HSYNC = 1;
  localparam int C_DE    = 2;
  localparam int C_SDATA = 3;
  localparam int C_WSEL  = 4;
  localparam int C_BCLK  = 5;
  localparam int C_CSN   = 6;

  typedef enum logic {
    XFER_PIXCLK = 1'b0,
    XFER_DIVCLK = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/bai_sample_shifter.sv
module bai_sample_shifter #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                in_ready,
  input  logic                adv_i,
  output logic                loaded_o,
  output logic                ser_bit_o,
  output logic                wsel_o
);
  localparam int FRAME_W = 2 * SAMPLE_W;
  localparam int PTR_W   = $clog2(FRAME_W);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(FRAME_W - 1);
  localparam logic [PTR_W-1:0] WS_RISE  = PTR_W'(SAMPLE_W - 1);
  localparam logic [PTR_W-1:0] WS_FALL  = PTR_W'(FRAME_W - 2);

  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic               loaded_q, loaded_d;
  logic               take;

  assign in_ready  = !loaded_q;
  assign take      = in_valid && in_ready;
  assign loaded_o  = loaded_q;
  assign ser_bit_o = loaded_q && frame_q[FRAME_W-1];
  // word select leads the channel change by one bit
  assign wsel_o    = (ptr_q >= WS_RISE) && (ptr_q <= WS_FALL);

  always_comb begin
    frame_d  = frame_q;
    ptr_d    = ptr_q;
    loaded_d = loaded_q;
    if (take) begin
      frame_d  = {in_left, in_right};
      ptr_d    = '0;
      loaded_d = 1'b1;
    end else if (loaded_q && adv_i) begin
      frame_d = frame_q << 1;
      if (ptr_q == PTR_LAST) begin
        ptr_d    = '0;
        loaded_d = 1'b0;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q  <= '0;
      ptr_q    <= '0;
      loaded_q <= 1'b0;
    end else begin
      frame_q  <= frame_d;
      ptr_q    <= ptr_d;
      loaded_q <= loaded_d;
    end
  end

  p_hold_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && !adv_i) |=> ($stable(ptr_q) && $stable(frame_q)));

  p_step_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && adv_i && ptr_q != PTR_LAST) |=> (ptr_q == $past(ptr_q) + 1'b1));
endmodule

// File: rtl/bai_bitclk_gen.sv
module bai_bitclk_gen
  import bai_pkg::*;
#(
  parameter int DIV_HALF = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic loaded_i,
  input  logic blank_i,
  output logic adv_o,
  output logic bclk_o,
  output logic cs_n_o
);
  localparam int PERIOD = 2 * DIV_HALF;
  localparam int PH_W   = $clog2(PERIOD);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
  localparam logic [PH_W-1:0] PH_HIGH = PH_W'(DIV_HALF);

  xfer_mode_e      mode;
  logic [PH_W-1:0] phase_q, phase_d;
  logic            run;

  assign mode = xfer_mode_e'(mode_i);
  assign run  = loaded_i && blank_i;

  always_comb begin
    phase_d = phase_q;
    adv_o   = 1'b0;
    bclk_o  = 1'b0;
    cs_n_o  = 1'b1;
    if (mode == XFER_PIXCLK) begin
      phase_d = '0;
      adv_o   = run;
      cs_n_o  = !run;
    end else begin
      if (!loaded_i) begin
        phase_d = '0;
      end else if (run) begin
        adv_o   = (phase_q == PH_LAST);
        phase_d = adv_o ? '0 : phase_q + 1'b1;
      end
      bclk_o = run && (phase_q >= PH_HIGH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  p_phase_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_i && !blank_i) |=> $stable(phase_q));
endmodule

// File: rtl/bai_word_pack.sv
module bai_word_pack
  import bai_pkg::*;
#(
  parameter int RGB_W = 18
) (
  input  logic [RGB_W-1:0]       rgb_i,
  input  logic                   vsync_i,
  input  logic                   hsync_i,
  input  logic                   de_i,
  input  logic                   sdata_i,
  input  logic                   wsel_i,
  input  logic                   bclk_i,
  input  logic                   cs_n_i,
  output logic [RGB_W+CTL_W-1:0] word_o
);
  logic [CTL_W-1:0] ctl;

  always_comb begin
    ctl          = '0;
    ctl[C_VSYNC] = vsync_i;
    ctl[C_HSYNC] = hsync_i;
    ctl[C_DE]    = de_i;
    ctl[C_SDATA] = sdata_i;
    ctl[C_WSEL]  = wsel_i;
    ctl[C_BCLK]  = bclk_i;
    ctl[C_CSN]   = cs_n_i;
    word_o       = {ctl, rgb_i};
  end
endmodule

// File: rtl/blank_audio_inserter.sv
module blank_audio_inserter
  import bai_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int RGB_W    = 18,
  parameter int DIV_HALF = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_i,
  input  logic [RGB_W-1:0]       rgb_i,
  input  logic                   vsync_i,
  input  logic                   hsync_i,
  input  logic                   de_i,
  input  logic                   aud_valid,
  input  logic [SAMPLE_W-1:0]    aud_left,
  input  logic [SAMPLE_W-1:0]    aud_right,
  output logic                   aud_ready,
  output logic [RGB_W+CTL_W-1:0] word_o
);
  localparam int IDX_SDATA = RGB_W + C_SDATA;
  localparam int IDX_BCLK  = RGB_W + C_BCLK;
  localparam int IDX_CSN   = RGB_W + C_CSN;

  logic rst_meta_q, rst_sync_q;
  logic sh_ready, loaded, adv, ser_bit, wsel, bclk, cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign aud_ready = sh_ready && rst_sync_q;

  bai_sample_shifter #(.SAMPLE_W(SAMPLE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .in_valid (aud_valid && rst_sync_q),
    .in_left  (aud_left),
    .in_right (aud_right),
    .in_ready (sh_ready),
    .adv_i    (adv),
    .loaded_o (loaded),
    .ser_bit_o(ser_bit),
    .wsel_o   (wsel)
  );

  bai_bitclk_gen #(.DIV_HALF(DIV_HALF)) u_bclk (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .mode_i  (mode_i),
    .loaded_i(loaded),
    .blank_i (!de_i),
    .adv_o   (adv),
    .bclk_o  (bclk),
    .cs_n_o  (cs_n)
  );

  bai_word_pack #(.RGB_W(RGB_W)) u_pack (
    .rgb_i  (rgb_i),
    .vsync_i(vsync_i),
    .hsync_i(hsync_i),
    .de_i   (de_i),
    .sdata_i(ser_bit),
    .wsel_i (wsel),
    .bclk_i (bclk),
    .cs_n_i (cs_n),
    .word_o (word_o)
  );

  p_quiet_video_r3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    de_i |-> (!word_o[IDX_BCLK] && word_o[IDX_CSN]));

  p_setup_edge_r5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (mode_i && $rose(word_o[IDX_BCLK])) |-> $stable(word_o[IDX_SDATA]));

  p_one_take_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (aud_valid && aud_ready) |=> !aud_ready);
endmodule

// File: tb/blank_audio_inserter_tb_top.sv
`timescale 1ns/1ps
module blank_audio_inserter_tb_top;
  localparam int H = 1;

  logic        clk;
  logic        rst_n;
  logic        mode_i;
  logic [17:0] rgb_i;
  logic        vsync_i, hsync_i, de_i;
  logic        aud_valid;
  logic [15:0] aud_left, aud_right;
  logic        aud_ready;
  logic [26:0] word_o;

  blank_audio_inserter #(.SAMPLE_W(16), .RGB_W(18), .DIV_HALF(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .rgb_i(rgb_i),
    .vsync_i(vsync_i), .hsync_i(hsync_i), .de_i(de_i),
    .aud_valid(aud_valid), .aud_left(aud_left), .aud_right(aud_right),
    .aud_ready(aud_ready), .word_o(word_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, vid_cnt = 0, act_len = 0, blk_len = 1;
  bit m_loaded = 0;
  int m_pos = 0, m_phase = 0;
  logic [31:0] m_data = '0;
  logic [31:0] pend_q[$];
  logic [31:0] sent_q[$];
  logic [31:0] rx_sh = '0;
  int rx_cnt = 0;
  bit prev_c5 = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic step();
    bit send, adv, c5e, c6e;
    @(negedge clk);
    de_i    = ((vid_cnt % (act_len + blk_len)) < act_len);
    vid_cnt++;
    rgb_i   = 18'(cyc * 37 + 5);
    hsync_i = cyc[2];
    vsync_i = cyc[5];
    cyc++;
    aud_valid = (pend_q.size() > 0);
    {aud_left, aud_right} = aud_valid ? pend_q[0] : 32'h0;
    #0.5;
    send = m_loaded && !de_i;
    c5e  = mode_i && send && (m_phase >= H);
    c6e  = !(!mode_i && send);
    check("R1 passthrough", 32'(word_o[20:0]), 32'({de_i, hsync_i, vsync_i, rgb_i}));
    check("R2 spare bits", 32'(word_o[26:25]), 32'h0);
    check(m_loaded ? "R6 data bit" : "R11 idle data", 32'(word_o[21]),
          32'(m_loaded && m_data[31 - m_pos]));
    check(m_loaded ? "R7 word select" : "R11 idle select", 32'(word_o[22]),
          32'(m_pos >= 15 && m_pos <= 30));
    check(de_i ? "R3 clock" : (mode_i ? "R5 clock" : "R4 clock"), 32'(word_o[23]), 32'(c5e));
    check(de_i ? "R3 select" : (mode_i ? "R5 select" : "R4 select"), 32'(word_o[24]), 32'(c6e));
    check("R9 ready", 32'(aud_ready), 32'(!m_loaded));
    // far-end receiver: capture on each bit-clock rising edge
    if ((!mode_i && !word_o[24]) || (mode_i && word_o[23] && !prev_c5)) begin
      check("R7 select at capture", 32'(word_o[22]), 32'(rx_cnt >= 15 && rx_cnt <= 30));
      rx_sh = {rx_sh[30:0], word_o[21]};
      rx_cnt++;
      if (rx_cnt == 32) begin
        rx_cnt = 0;
        if (sent_q.size() > 0) check("R8 R6 rebuilt frame", rx_sh, sent_q.pop_front());
        else check("R8 unexpected frame", rx_sh, 32'hxxxx_xxxx);
      end
    end
    prev_c5 = word_o[23];
    // reference update for the coming edge
    if (!m_loaded) begin
      if (aud_valid) begin
        m_data = pend_q.pop_front();
        sent_q.push_back(m_data);
        m_loaded = 1; m_pos = 0; m_phase = 0;
      end
    end else if (!de_i) begin
      adv = 0;
      if (!mode_i) adv = 1;
      else begin
        m_phase++;
        if (m_phase == 2 * H) begin m_phase = 0; adv = 1; end
      end
      if (adv) begin
        if (m_pos == 31) begin m_loaded = 0; m_pos = 0; end
        else m_pos++;
      end
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; mode_i = mode; de_i = 1'b1; aud_valid = 1'b0;
    m_loaded = 0; m_pos = 0; m_phase = 0; rx_cnt = 0; prev_c5 = 0;
    pend_q.delete(); sent_q.delete();
    #0.5;
    check("R10 ready in reset", 32'(aud_ready), 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    check("R10 ready held after release", 32'(aud_ready), 32'h0);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_test(input logic mode, input int act, input int blk, input int nsamp,
                          input int seed);
    int guard = 0;
    do_reset(mode);
    act_len = act; blk_len = blk; vid_cnt = act;
    step();
    check("R10 idle after reset", 32'({aud_ready, word_o[24:21]}), 32'(5'b1_1000));
    pend_q.push_back({16'h8000, 16'h0001});
    for (int s = 1; s < nsamp; s++)
      pend_q.push_back({16'(s * 16'h1357 + seed), 16'(s * 16'h2b1d ^ seed)});
    while ((pend_q.size() > 0 || m_loaded) && guard < 20000) begin
      step();
      guard++;
    end
    if (guard >= 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog mode %0d: actual timeout expected drain", mode);
    end
    repeat (6) step();
    check("R8 no partial frame", 32'(rx_cnt), 32'h0);
    check("R8 all frames seen", 32'(sent_q.size()), 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; mode_i = 1'b0; de_i = 1'b1; aud_valid = 1'b0;
    rgb_i = '0; vsync_i = 1'b0; hsync_i = 1'b0; aud_left = '0; aud_right = '0;
    run_test(1'b0, 20, 40, 4, 16'h0a5c);  // R4 long gaps
    run_test(1'b0, 7, 5, 5, 16'h3c91);    // R8 pixel mode, gaps shorter than a frame
    run_test(1'b1, 10, 40, 3, 16'h77e2);  // R5 divided clock
    run_test(1'b1, 4, 3, 4, 16'h1f08);    // R8 odd gap splits a clock period
    run_test(1'b0, 0, 1, 3, 16'h5aa5);    // R9 continuous blanking, back-to-back takes
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule